// File: doc/BRIEF.md
# Dual-Rail Four-Phase Handshake Pipeline

This block is a linear chain of `DEPTH` stages that moves `W`-bit words from a sender to a receiver. Every bit travels on a pair of rails, and every channel between neighbours carries those rails forward and one enable wire backward. Transfers follow a return-to-zero protocol in four phases. The sender presents a valid word. The stage lowers its enable. The sender returns the rails to the spacer. The stage raises its enable again. The chain is clocked, so each rising edge stands for one event step of the self-timed circuit it models.

The parameter `FULL` picks how each stage handles the return-to-zero phase. When `FULL` is 0, each bit of a stage behaves as a Muller C-element of its input rail and the downstream enable. The stage reaches the spacer only after its own input has reached the spacer, so occupied stages alternate with empty ones. When `FULL` is 1, a stage drops its output as soon as the downstream stage acknowledges it, whatever its input is doing. This lets every stage hold a word at the same time. A sticky flag reports any bit that shows both rails high.

Top module: `dual_rail_pipe`

## Requirements
- R1: While `rst` is high at a clock edge, every output rail goes low, `in_en` goes high and `err` goes low.
- R2: A bit with value 1 is carried by its true rail high and its false rail low. Value 0 is the reverse. The spacer has both rails low. Output words keep this encoding.
- R3: Words leave the output in the order they were accepted, with their values unchanged, for any receiver response delay.
- R4: `in_en` falls only after the input word was complete, with every bit valid. It rises again only after the input word was entirely spacer.
- R5: Once an output rail is high, it stays high while `out_en` is high. No output rail rises while `out_en` is low.
- R6: With `FULL`=0 and a receiver that never acknowledges, the chain accepts exactly `DEPTH`/2 words.
- R7: With `FULL`=1 and a receiver that never acknowledges, the chain accepts exactly `DEPTH` words.
- R8: While the input stays at the spacer, no output rail toggles and `in_en` stays high.
- R9: Any bit with both rails high at the input or output sets `err` by the next edge. `err` then stays high until reset.
- R10: A reset applied while words are in flight returns every output rail to the spacer and raises `in_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Event-step clock |
| rst | input | 1 | Synchronous reset, active high |
| in_t | input | W | True rails of the input word |
| in_f | input | W | False rails of the input word |
| in_en | output | 1 | Enable back to the sender; low acknowledges a word |
| out_t | output | W | True rails of the output word |
| out_f | output | W | False rails of the output word |
| out_en | input | 1 | Enable from the receiver; low acknowledges a word |
| err | output | 1 | Sticky flag for a bit with both rails high |

## Verification
Both buffering variants receive the same streams, each with a different receiver delay:
- an incrementing sequence, which exposes reordering or dropped words;
- words that alternate between all-zero and all-ones, which drive every false rail and then every true rail;
- 0x55 and 0xAA, which catch swapped neighbour bits;
- a walking one, which isolates each bit lane.

A stalled receiver with a sender pushing until it is refused separates half from full capacity. The order check after the stall confirms that the refused word is not lost. Injecting both rails high, then resetting with words in flight, exercises the error flag and the return to the spacer.

// File: rtl/dual_rail_pipe.sv
module dual_rail_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter bit FULL  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         in_en,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  input  logic         out_en,
  output logic         err
);

  logic [W-1:0] rt [0:DEPTH];
  logic [W-1:0] rf [0:DEPTH];
  logic         en [0:DEPTH];

  assign rt[0]     = in_t;
  assign rf[0]     = in_f;
  assign en[DEPTH] = out_en;
  assign in_en     = en[0];
  assign out_t     = rt[DEPTH];
  assign out_f     = rf[DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [W-1:0] qt, qf;
    assign rt[s+1] = qt;
    assign rf[s+1] = qf;

    if (!FULL) begin : g_half
      logic         done;
      logic [W-1:0] dn;
      assign dn    = {W{en[s+1]}};
      assign en[s] = ~done;
      always_ff @(posedge clk) begin
        if (rst) begin
          qt   <= '0;
          qf   <= '0;
          done <= 1'b0;
        end else begin
          qt <= (rt[s] & dn) | (qt & (rt[s] | dn));
          qf <= (rf[s] & dn) | (qf & (rf[s] | dn));
          if (&(qt | qf))       done <= 1'b1;
          else if (~|(qt | qf)) done <= 1'b0;
        end
      end
    end else begin : g_full
      logic took, in_valid, in_spacer, grab;
      assign in_valid  = &(rt[s] | rf[s]);
      assign in_spacer = ~|(rt[s] | rf[s]);
      assign grab      = in_valid && en[s+1] && ~|(qt | qf) && !took;
      assign en[s]     = ~took;
      always_ff @(posedge clk) begin
        if (rst) begin
          qt   <= '0;
          qf   <= '0;
          took <= 1'b0;
        end else begin
          if (grab) begin
            qt <= rt[s];
            qf <= rf[s];
          end else if (!en[s+1]) begin
            qt <= '0;
            qf <= '0;
          end
          if (grab)           took <= 1'b1;
          else if (in_spacer) took <= 1'b0;
        end
      end
    end
  end

  logic bad;
  always_comb begin
    bad = 1'b0;
    for (int k = 0; k <= DEPTH; k++) bad = bad | (|(rt[k] & rf[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= err | bad;
  end

  p_ack_after_data_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(in_en) |-> $past(&(in_t | in_f)));
  p_release_after_spacer_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(in_en) |-> $past(~|(in_t | in_f)));
  p_hold_valid_r5: assert property (@(posedge clk) disable iff (rst)
    out_en |=> ((($past(out_t) & ~out_t) == '0) && (($past(out_f) & ~out_f) == '0)));
  p_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (((out_t & ~$past(out_t)) == '0) && ((out_f & ~$past(out_f)) == '0)));
  p_in_illegal_r9: assert property (@(posedge clk) disable iff (rst)
    (|(in_t & in_f)) |=> err);
  p_out_illegal_r9: assert property (@(posedge clk) disable iff (rst)
    (|(out_t & out_f)) |-> err);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: tb/dual_rail_pipe_tb.sv
module dual_rail_pipe_tb;
  localparam int W = 8;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] it [2];
  logic [W-1:0] itf[2];
  logic [W-1:0] ot [2];
  logic [W-1:0] otf[2];
  logic         ien[2];
  logic         oen[2];
  logic         er [2];

  dual_rail_pipe #(.W(W), .DEPTH(N), .FULL(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_t(it[0]), .in_f(itf[0]), .in_en(ien[0]),
    .out_t(ot[0]), .out_f(otf[0]), .out_en(oen[0]), .err(er[0]));
  dual_rail_pipe #(.W(W), .DEPTH(N), .FULL(1'b1)) u_dut_full (
    .clk(clk), .rst(rst), .in_t(it[1]), .in_f(itf[1]), .in_en(ien[1]),
    .out_t(ot[1]), .out_f(otf[1]), .out_en(oen[1]), .err(er[1]));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [W-1:0] exq [2][$];
  bit mon_on [2];
  int rx_dly [2];
  bit pend [2];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  for (genvar g = 0; g < 2; g++) begin : g_mon
    initial begin
      forever begin
        @(negedge clk);
        if (mon_on[g] && !rst && (&(ot[g] | otf[g]))) begin
          chk(otf[g] == ~ot[g], "R2", "output rail pair", otf[g], ~ot[g]);
          if (exq[g].size() == 0) chk(1'b0, "R3", "unexpected word", ot[g], 0);
          else begin
            logic [W-1:0] e;
            e = exq[g].pop_front();
            chk(ot[g] == e, "R3", $sformatf("word order mode %0d", g), ot[g], e);
          end
          repeat (rx_dly[g]) @(negedge clk);
          oen[g] = 1'b0;
          for (int t = 0; t < 1000; t++) begin
            if (ot[g] == '0 && otf[g] == '0) break;
            @(negedge clk);
          end
          oen[g] = 1'b1;
        end
      end
    end
  end

  task automatic send(int m, logic [W-1:0] v, int to, output bit ok);
    bit seen;
    ok = 1'b0;
    seen = 1'b0;
    for (int t = 0; t < to; t++) begin
      if (ien[m]) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    if (!seen) return;
    it[m] = v;
    itf[m] = ~v;
    exq[m].push_back(v);
    seen = 1'b0;
    for (int t = 0; t < to; t++) begin
      @(negedge clk);
      if (!ien[m]) begin seen = 1'b1; break; end
    end
    if (!seen) begin pend[m] = 1'b1; return; end
    it[m] = '0;
    itf[m] = '0;
    ok = 1'b1;
  endtask

  task automatic drain(int m, string req);
    for (int t = 0; t < 2000; t++) begin
      if (exq[m].size() == 0 && ot[m] == '0 && otf[m] == '0) break;
      @(negedge clk);
    end
    chk(exq[m].size() == 0, req, $sformatf("words left mode %0d", m), exq[m].size(), 0);
  endtask

  task automatic do_reset();
    for (int m = 0; m < 2; m++) begin
      mon_on[m] = 1'b0; it[m] = '0; itf[m] = '0; oen[m] = 1'b1; pend[m] = 1'b0;
      exq[m].delete();
    end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R3", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int cnt, bad;
    logic [W-1:0] v;
    for (int m = 0; m < 2; m++) begin
      it[m] = '0; itf[m] = '0; oen[m] = 1'b1; mon_on[m] = 1'b0; rx_dly[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(ot[m] == '0 && otf[m] == '0, "R1", "reset rails", {ot[m], otf[m]}, 0);
      chk(ien[m] == 1'b1 && er[m] == 1'b0, "R1", "reset in_en/err", {ien[m], er[m]}, 2);
    end

    bad = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++)
        if (ot[m] != '0 || otf[m] != '0 || !ien[m]) bad++;
    end
    chk(bad == 0, "R8", "idle toggles", bad, 0);

    for (int m = 0; m < 2; m++) begin
      mon_on[m] = 1'b1;
      for (int kind = 0; kind < 4; kind++) begin
        rx_dly[m] = kind;
        for (int i = 0; i < 12; i++) begin
          case (kind)
            0: v = W'(i * 17 + 3);
            1: v = (i % 2 == 0) ? '0 : '1;
            2: v = (i % 2 == 0) ? W'('h55) : W'('hAA);
            default: v = W'(1) << (i % W);
          endcase
          send(m, v, 400, ok);
          chk(ok, "R4", $sformatf("handshake mode %0d kind %0d", m, kind), ok, 1);
        end
        drain(m, "R3");
      end
      rx_dly[m] = 0;
    end

    do_reset();
    for (int m = 0; m < 2; m++) begin
      cnt = 0;
      for (int k = 0; k < N + 2; k++) begin
        send(m, W'(k + 8'h21), 40, ok);
        if (!ok) break;
        cnt++;
      end
      if (m == 0) chk(cnt == N / 2, "R6", "half-buffer occupancy", cnt, N / 2);
      else        chk(cnt == N, "R7", "full-buffer occupancy", cnt, N);
      mon_on[m] = 1'b1;
      if (pend[m]) begin
        for (int t = 0; t < 400; t++) begin
          @(negedge clk);
          if (!ien[m]) break;
        end
        it[m] = '0; itf[m] = '0; pend[m] = 1'b0;
      end
      drain(m, "R3");
    end

    for (int m = 0; m < 2; m++) begin
      mon_on[m] = 1'b0;
      oen[m] = 1'b1;
      send(m, W'('h3C), 40, ok);
      send(m, W'('hC3), 40, ok);
    end
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin it[m] = '0; itf[m] = '0; end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      exq[m].delete(); pend[m] = 1'b0;
      chk(ot[m] == '0 && otf[m] == '0 && ien[m], "R10", "reset in flight",
          {ien[m], ot[m], otf[m]}, 1 << (2 * W));
    end

    for (int m = 0; m < 2; m++) begin
      it[m] = W'(1); itf[m] = W'(1);
    end
    @(negedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) chk(er[m], "R9", "illegal sets err", er[m], 1);
    for (int m = 0; m < 2; m++) begin it[m] = '0; itf[m] = '0; end
    repeat (6) @(negedge clk);
    for (int m = 0; m < 2; m++) chk(er[m], "R9", "err sticky", er[m], 1);
    do_reset();
    for (int m = 0; m < 2; m++) chk(!er[m], "R1", "err cleared by reset", er[m], 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule